// File: doc/BRIEF.md
# Modem Control and Status Register Unit

This block keeps the modem control register and the modem status register of a 16550-style serial port. It brings the four incoming handshake lines (carrier detect, ring indicator, data set ready, clear to send) through synchronizer chains. It records each change as a sticky change flag, and it drives the four outgoing handshake pins from the control register. The host writes the control register with a one-cycle write strobe. It reads the status byte from a port that is always valid. It signals the read with a one-cycle strobe, and that strobe clears the change flags.

A loopback test mode is selected by a control bit. In this mode the status lines are taken from the control bits instead of the pins, and the request-to-send and terminal-ready pins are forced inactive. A modem-status request output goes to the interrupt logic whenever a change flag is set and the caller's enable input is high.

Top module: `mdm_status_unit`

## Requirements
- R1: After reset, stat_q reads 8'hB0 (carrier, data-set-ready and clear-to-send high, no change flags), ctl_q reads 8'h08, out2_pin is 1, dtr_pin, rts_pin, out1_pin and msi_req are 0.
- R2: A write stores wr_data[4:0] into the control register, and ctl_q[7:5] always reads 0. Outside loopback the pins follow it: bit 0 drives dtr_pin, bit 1 drives rts_pin, bit 2 drives out1_pin, bit 3 drives out2_pin. Bit 4 selects loopback.
- R3: The status upper nibble follows the pins as bit 7 carrier, bit 6 ring, bit 5 data-set-ready and bit 4 clear-to-send. With two synchronizer stages, a pin change shows in stat_q after exactly three rising clock edges.
- R4: Status bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send) are set on any change of their line. They stay set until read.
- R5: Status bit 2 is set only when the ring line goes from 1 to 0, never on a rise.
- R6: A read strobe clears stat_q[3:0] at the next edge and leaves stat_q[7:4] alone. A change detected at that same edge still sets its flag.
- R7: In loopback the upper nibble shows control bit 3 as carrier, bit 2 as ring, bit 0 as data-set-ready and bit 1 as clear-to-send, one edge after the write. The input pins have no effect.
- R8: In loopback, rts_pin and dtr_pin are 0, and out1_pin and out2_pin still follow the control register.
- R9: msi_req is 1 exactly when msi_en is 1 and any of stat_q[3:0] is set.
- R10: In loopback, changes of the looped control bits set the change flags under the same rules as pin changes, including the falling-only ring rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write data |
| stat_rd | input | 1 | Status read strobe, clears change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| dcd_pin | input | 1 | Carrier detect line, asynchronous |
| ri_pin | input | 1 | Ring indicator line, asynchronous |
| dsr_pin | input | 1 | Data set ready line, asynchronous |
| cts_pin | input | 1 | Clear to send line, asynchronous |
| ctl_q | output | 8 | Control register readback |
| stat_q | output | 8 | Status byte: lines in 7:4, change flags in 3:0 |
| dtr_pin | output | 1 | Terminal ready output |
| rts_pin | output | 1 | Request to send output |
| out1_pin | output | 1 | General output 1 |
| out2_pin | output | 1 | General output 2 |
| msi_req | output | 1 | Modem-status change request |

## Verification
The assertions take for granted that the read strobe is low while reset is asserted. They also take for granted that every change of the status upper nibble comes from a synchronized line or a control write, so a change flag never rises without a matching nibble change. The bench holds the pins at the reset image of the status register during reset, so no change is seen when reset ends. It changes pins and issues strobes only on falling clock edges, and it waits out the synchronizer latency before it samples.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // control register bit positions (decoded by the pin drivers and loopback map)
   localparam int CTL_DTR  = 0;
   localparam int CTL_RTS  = 1;
   localparam int CTL_OUT1 = 2;
   localparam int CTL_OUT2 = 3;
   localparam int CTL_LOOP = 4;
   localparam int CTL_W    = 5;

   // status nibble ordering: {carrier, ring, set-ready, clear-to-send}
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;
   localparam int LN_W   = 4;

   typedef logic [LN_W-1:0]  line_vec_t;
   typedef logic [CTL_W-1:0] ctl_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdm_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
   import mdm_pkg::*;
#(
   parameter ctl_vec_t RST_CTL    = 5'b01000,
   parameter bit       ACTIVE_LOW = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  logic [7:0] wr_data,
   output ctl_vec_t ctl,
   output logic     dtr_o,
   output logic     rts_o,
   output logic     out1_o,
   output logic     out2_o
);
   logic [3:0] lvl;   // {out2, out1, rts, dtr} as logical levels

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl <= RST_CTL;
      else if (wr_en) ctl <= wr_data[CTL_W-1:0];
   end

   always_comb begin
      lvl[0] = ctl[CTL_DTR] & ~ctl[CTL_LOOP];
      lvl[1] = ctl[CTL_RTS] & ~ctl[CTL_LOOP];
      lvl[2] = ctl[CTL_OUT1];
      lvl[3] = ctl[CTL_OUT2];
   end

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign {out2_o, out1_o, rts_o, dtr_o} = ~lvl;
      end else begin : g_direct
         assign {out2_o, out1_o, rts_o, dtr_o} = lvl;
      end
   endgenerate
endmodule

// File: rtl/mdm_stat_tracker.sv
module mdm_stat_tracker
   import mdm_pkg::*;
#(
   parameter line_vec_t RST_LINES = 4'b1011
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_vec_t src,
   input  logic      clr,
   output line_vec_t cur,
   output line_vec_t delta
);
   line_vec_t set_v;

   always_comb begin
      set_v         = src ^ cur;
      set_v[LN_RI]  = cur[LN_RI] & ~src[LN_RI];   // falling edge only
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur   <= RST_LINES;
         delta <= '0;
      end else begin
         cur   <= src;
         delta <= (clr ? '0 : delta) | set_v;
      end
   end
endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
   import mdm_pkg::*;
#(
   parameter int        SYNC_STAGES     = 2,
   parameter bit        PINS_ACTIVE_LOW = 1'b0,
   parameter line_vec_t RST_LINES       = 4'b1011,
   parameter ctl_vec_t  RST_CTL         = 5'b01000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [7:0] wr_data,
   input  logic       stat_rd,
   input  logic       msi_en,
   input  logic       dcd_pin,
   input  logic       ri_pin,
   input  logic       dsr_pin,
   input  logic       cts_pin,
   output logic [7:0] ctl_q,
   output logic [7:0] stat_q,
   output logic       dtr_pin,
   output logic       rts_pin,
   output logic       out1_pin,
   output logic       out2_pin,
   output logic       msi_req
);
   localparam int PAD_W = 8 - CTL_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mdm_status_unit: SYNC_STAGES below 2");
      end
      if (RST_CTL[CTL_LOOP]) begin : g_bad_rst
         $error("mdm_status_unit: reset must not select loopback");
      end
   endgenerate

   line_vec_t raw_lines, sync_lines, loop_lines, src_lines, cur_lines, delta;
   ctl_vec_t  ctl;

   generate
      if (PINS_ACTIVE_LOW) begin : g_in_inv
         assign raw_lines = ~{dcd_pin, ri_pin, dsr_pin, cts_pin};
      end else begin : g_in_direct
         assign raw_lines = {dcd_pin, ri_pin, dsr_pin, cts_pin};
      end
   endgenerate

   mdm_sync #(.WIDTH(LN_W), .STAGES(SYNC_STAGES), .RST_VAL(RST_LINES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines));

   mdm_ctl_reg #(.RST_CTL(RST_CTL), .ACTIVE_LOW(PINS_ACTIVE_LOW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(wr_data), .ctl(ctl),
      .dtr_o(dtr_pin), .rts_o(rts_pin), .out1_o(out1_pin), .out2_o(out2_pin));

   always_comb begin
      loop_lines[LN_DCD] = ctl[CTL_OUT2];
      loop_lines[LN_RI]  = ctl[CTL_OUT1];
      loop_lines[LN_DSR] = ctl[CTL_DTR];
      loop_lines[LN_CTS] = ctl[CTL_RTS];
      src_lines = ctl[CTL_LOOP] ? loop_lines : sync_lines;
   end

   mdm_stat_tracker #(.RST_LINES(RST_LINES)) u_track (
      .clk(clk), .rst_n(rst_n), .src(src_lines), .clr(stat_rd),
      .cur(cur_lines), .delta(delta));

   assign ctl_q   = {{PAD_W{1'b0}}, ctl};
   assign stat_q  = {cur_lines, delta};
   assign msi_req = msi_en & (|delta);
endmodule

// File: rtl/mdm_status_unit_chk.sv
module mdm_status_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_rd,
   input logic       msi_en,
   input logic [7:0] ctl_q,
   input logic [7:0] stat_q,
   input logic       dtr_pin,
   input logic       rts_pin,
   input logic       msi_req
);
   AST_CTL_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[7:5] == 3'b000);                                            // R2
   AST_LOOP_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[4] |-> (!rts_pin && !dtr_pin));                             // R8
   AST_TERI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[2]) |-> $fell(stat_q[6]));                           // R5
   AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_rd) |-> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]))); // R4
   AST_DCD_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[7] != $past(stat_q[7])) |-> stat_q[3]);                   // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_rd) && $stable(stat_q[7:4])) |-> (stat_q[3:0] == 4'h0)); // R6
   AST_MSI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req == (msi_en && (stat_q[3:0] != 4'h0)));                   // R9
endmodule

bind mdm_status_unit mdm_status_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .msi_en(msi_en),
   .ctl_q(ctl_q), .stat_q(stat_q), .dtr_pin(dtr_pin), .rts_pin(rts_pin),
   .msi_req(msi_req));

// File: tb/mdm_status_unit_bench.sv
module mdm_status_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, stat_rd = 1'b0, msi_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic dcd_pin = 1'b1, ri_pin = 1'b0, dsr_pin = 1'b1, cts_pin = 1'b1;
   logic [7:0] ctl_q, stat_q;
   logic dtr_pin, rts_pin, out1_pin, out2_pin, msi_req;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mdm_status_unit u_mdm_status_unit (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_data(wr_data),
      .stat_rd(stat_rd), .msi_en(msi_en), .dcd_pin(dcd_pin), .ri_pin(ri_pin),
      .dsr_pin(dsr_pin), .cts_pin(cts_pin), .ctl_q(ctl_q), .stat_q(stat_q),
      .dtr_pin(dtr_pin), .rts_pin(rts_pin), .out1_pin(out1_pin),
      .out2_pin(out2_pin), .msi_req(msi_req));

   // vector: {pins dcd,ri,dsr,cts [12:9], read [8], expected stat [7:0]}
   localparam logic [12:0] VEC [9] = '{
      {4'b1011, 1'b0, 8'hB0},
      {4'b1010, 1'b0, 8'hA1},
      {4'b1110, 1'b1, 8'hE1},
      {4'b1010, 1'b1, 8'hA4},
      {4'b0010, 1'b0, 8'h28},
      {4'b0000, 1'b1, 8'h0A},
      {4'b1111, 1'b1, 8'hFB},
      {4'b0101, 1'b1, 8'h5A},
      {4'b0001, 1'b1, 8'h14}
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%02h exp=%02h", req, got, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_read();
      stat_rd = 1'b1; ticks(1); stat_rd = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] v);
      wr_data = v; ctl_wr = 1'b1; ticks(1); ctl_wr = 1'b0;
   endtask

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(1);
      // R1 reset state
      chk("R1 stat", stat_q, 8'hB0);
      chk("R1 ctl", ctl_q, 8'h08);
      chk("R1 pins", {out2_pin, out1_pin, rts_pin, dtr_pin, msi_req}, 8'h10);

      // R3/R4/R5/R6 vector walk
      for (int v = 0; v < 9; v++) begin
         {dcd_pin, ri_pin, dsr_pin, cts_pin} = VEC[v][12:9];
         ticks(4);
         chk($sformatf("R4/R5 vec%0d", v), stat_q, VEC[v][7:0]);
         if (VEC[v][8]) begin
            do_read();
            chk($sformatf("R6 vec%0d read", v), stat_q, {VEC[v][7:4], 4'h0});
         end
      end

      // R3 latency: exactly three edges
      cts_pin = 1'b0;            // lines now 0000
      ticks(2);
      chk("R3 before", stat_q, 8'h10);
      ticks(1);
      chk("R3 after", stat_q, 8'h01);

      // R9 request gating
      chk("R9 disabled", {7'h0, msi_req}, 8'h00);
      msi_en = 1'b1; #1;
      chk("R9 enabled", {7'h0, msi_req}, 8'h01);
      do_read();
      chk("R9 after read", {7'h0, msi_req}, 8'h00);

      // R6 read coinciding with a change: new flag survives
      cts_pin = 1'b1;
      ticks(2);
      do_read();                 // read strobe at the detecting edge
      chk("R6 same-edge", stat_q, 8'h11);
      do_read();

      // R2 control write and pins
      do_write(8'hEF);
      chk("R2 ctl", ctl_q, 8'h0F);
      chk("R2 pins", {4'h0, out2_pin, out1_pin, rts_pin, dtr_pin}, 8'h0F);

      // R7/R8 loopback: DTR+OUT1 -> lines 0110
      do_write(8'h15);
      chk("R8 pins", {4'h0, out2_pin, out1_pin, rts_pin, dtr_pin}, 8'h04);
      ticks(1);
      chk("R7 loop map", stat_q, 8'h63);
      do_read();
      {dcd_pin, ri_pin, dsr_pin, cts_pin} = 4'b1001;
      ticks(4);
      chk("R7 pins ignored", stat_q, 8'h60);
      // R10: RTS+OUT2 -> lines 1001, ring falls
      do_write(8'h1A);
      ticks(1);
      chk("R10 loop flags", stat_q, 8'h9F);
      chk("R8 out2", {6'h0, out2_pin, rts_pin}, 8'h02);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=hung exp=done");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule